// File: doc/BRIEF.md
# Backplane reset and bus timeout controller

This block sits on the system-controller board of a slotted 32-bit backplane. It has two jobs. The first is to drive the shared active-low reset line. After power comes up it holds the line low for a long settle period. When another board pulls the line low for at least two clock cycles, it treats that as a system restart and stretches it to the same full period. Each time it lets the line go, it emits a one-cycle pulse that tells self-testing boards to begin.

The second job is to watch bus transactions. A transaction begins with a start strobe and normally ends with a slave acknowledge. If no acknowledge arrives within a fixed window, the block answers in the slave's place. It gives a one-cycle acknowledge carrying a timeout status code, so the master is never left waiting. An access to an address where no slave responds is the intended way to exercise this path.

Both windows come from a clock-rate parameter given in kHz. A milliseconds parameter sets the reset hold and a microseconds parameter sets the timeout. The defaults are 100 ms and 25 us, and small values make short simulations possible.

Top module: `bus_sysctl`

## Requirements
- R1: `rst_drive_n` is 0 while `por_n` is 0. After `por_n` rises it stays 0 until the HOLD_CYC-th rising clock edge, where HOLD_CYC = CLK_KHZ*HOLD_MS, and at that edge it goes to 1.
- R2: `selftest_o` is 1 for exactly the first clock cycle in which `rst_drive_n` is 1 after every release, and 0 at all other times.
- R3: The block may be releasing the line (`rst_drive_n` = 1) while `rst_bus_n` is sampled 0 on two consecutive rising edges. In that case `rst_drive_n` goes to 0 at the second edge and is released HOLD_CYC edges later, followed by a new R2 pulse.
- R4: If `rst_bus_n` is 0 at only one rising edge, `rst_drive_n` is not affected.
- R5: TMO_CYC = ceil(CLK_KHZ*TMO_US/1000). A transaction starts at the edge where `start_i` is 1. If `ack_i` is not 1 at any of the following TMO_CYC edges, `tmo_ack_o` is 1 for one cycle after the TMO_CYC-th edge.
- R6: `tmo_stat_o` is 2'b10 (timeout) in the cycle `tmo_ack_o` is 1, and 2'b00 in every other cycle.
- R7: An `ack_i` sampled at any edge up to and including the TMO_CYC-th edge after the start ends the transaction, and no timeout follows.
- R8: A new `start_i` while a transaction is pending restarts the full TMO_CYC window from that edge.
- R9: A transaction produces at most one timeout acknowledge. After it the block stays idle until the next `start_i`.
- R10: While `rst_drive_n` is 0, transactions are not tracked and `tmo_ack_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-good indication, low while power is not stable (asynchronous) |
| rst_bus_n | input | 1 | Level of the shared open-drain reset line as seen on the backplane |
| start_i | input | 1 | One-cycle strobe: a bus transaction begins |
| ack_i | input | 1 | One-cycle strobe: a slave acknowledged the transaction |
| rst_drive_n | output | 1 | Drives the shared reset line low when 0 |
| tmo_ack_o | output | 1 | One-cycle acknowledge issued on a bus timeout |
| tmo_stat_o | output | 2 | Status returned with `tmo_ack_o`: 2'b10 timeout, else 2'b00 |
| selftest_o | output | 1 | One-cycle pulse to start self-tests after reset release |

## Verification
Random transactions draw the acknowledge delay from a range that covers both sides of the window. This checks that the timeout appears on exactly the right cycle or not at all. Directed cases place the acknowledge one edge before the limit, exactly on it, and one edge past it, and these settle the off-by-one boundary. A restart by a second start strobe separates a counter that clears on start from one that keeps running. On the reset side, a one-cycle low pulse and a two-cycle low pulse on the bus line are compared, which tells the glitch filter apart from a real restart request. The hold length is measured both after power-up and after an external request. A start issued during the hold shows that no timeout leaks out while reset is driven.

// File: rtl/bus_sysctl.sv
module bus_sysctl #(
  parameter int CLK_KHZ = 25000,
  parameter int HOLD_MS = 100,
  parameter int TMO_US  = 25
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_bus_n,
  input  logic       start_i,
  input  logic       ack_i,
  output logic       rst_drive_n,
  output logic       tmo_ack_o,
  output logic [1:0] tmo_stat_o,
  output logic       selftest_o
);
  localparam int HOLD_CYC = CLK_KHZ * HOLD_MS;
  localparam int TMO_CYC  = (CLK_KHZ * TMO_US + 999) / 1000;
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [1:0] ST_TIMEOUT = 2'b10;

  logic [HW-1:0] hold_cnt;
  logic          low_seen;
  logic [TW-1:0] tcnt;
  logic          busy;

  wire req_ok   = !rst_bus_n && low_seen && rst_drive_n;
  wire hold_end = (hold_cnt == HW'(HOLD_CYC - 1));
  wire tmo_end  = (tcnt == TW'(TMO_CYC - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_drive_n <= 1'b0;
      hold_cnt    <= '0;
      low_seen    <= 1'b0;
      selftest_o  <= 1'b0;
    end else begin
      selftest_o <= 1'b0;
      low_seen   <= !rst_bus_n && rst_drive_n;
      if (req_ok) begin
        rst_drive_n <= 1'b0;
        hold_cnt    <= '0;
        low_seen    <= 1'b0;
      end else if (!rst_drive_n) begin
        if (hold_end) begin
          rst_drive_n <= 1'b1;
          selftest_o  <= 1'b1;
        end else begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy       <= 1'b0;
      tcnt       <= '0;
      tmo_ack_o  <= 1'b0;
      tmo_stat_o <= 2'b00;
    end else begin
      tmo_ack_o  <= 1'b0;
      tmo_stat_o <= 2'b00;
      if (!rst_drive_n) begin
        busy <= 1'b0;
        tcnt <= '0;
      end else if (start_i) begin
        busy <= 1'b1;
        tcnt <= '0;
      end else if (ack_i) begin
        busy <= 1'b0;
        tcnt <= '0;
      end else if (busy) begin
        if (tmo_end) begin
          busy       <= 1'b0;
          tmo_ack_o  <= 1'b1;
          tmo_stat_o <= ST_TIMEOUT;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (por_n) a_r1_hold_bound: assert (hold_cnt < HW'(HOLD_CYC));
  end

  a_r2_pulse_on_release: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_drive_n) |-> selftest_o);
  a_r2_pulse_only_released: assert property (@(posedge clk) disable iff (!por_n)
    selftest_o |-> rst_drive_n);
  a_r6_status_code: assert property (@(posedge clk) disable iff (!por_n)
    tmo_ack_o |-> (tmo_stat_o == ST_TIMEOUT));
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!por_n)
    (ack_i && !start_i) |=> !tmo_ack_o);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!por_n)
    tmo_ack_o |=> !tmo_ack_o);
  a_r10_quiet_in_reset: assert property (@(posedge clk) disable iff (!por_n)
    !rst_drive_n |=> !tmo_ack_o);
endmodule

// File: tb/tb_bus_sysctl.sv
module tb_bus_sysctl;
  localparam int CLK_KHZ = 400;
  localparam int HOLD_MS = 1;
  localparam int TMO_US  = 25;
  localparam int HOLD_CYC = CLK_KHZ * HOLD_MS;
  localparam int TMO_CYC  = (CLK_KHZ * TMO_US + 999) / 1000;

  logic clk = 1'b0;
  logic por_n = 1'b0, ext_n = 1'b1, start_i = 1'b0, ack_i = 1'b0;
  logic rst_drive_n, tmo_ack_o, selftest_o;
  logic [1:0] tmo_stat_o;
  wire rst_bus_n = rst_drive_n & ext_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2ns clk = ~clk;

  bus_sysctl #(.CLK_KHZ(CLK_KHZ), .HOLD_MS(HOLD_MS), .TMO_US(TMO_US)) dut (
    .clk(clk), .por_n(por_n), .rst_bus_n(rst_bus_n), .start_i(start_i),
    .ack_i(ack_i), .rst_drive_n(rst_drive_n), .tmo_ack_o(tmo_ack_o),
    .tmo_stat_o(tmo_stat_o), .selftest_o(selftest_o));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_tmo_idx(int d, int rs);
    int lim = rs + TMO_CYC;
    return (d > lim) ? lim + 1 : 0;
  endfunction

  task automatic run_txn(int d, int rs);
    int hits = 0, idx = 0;
    int e = exp_tmo_idx(d, rs);
    @(negedge clk);
    start_i = 1'b1;
    for (int i = 1; i <= rs + TMO_CYC + 4; i++) begin
      @(negedge clk);
      start_i = (i == rs && rs != 0);
      chk("R6 status", tmo_stat_o, tmo_ack_o ? 2 : 0);
      if (tmo_ack_o) begin hits++; idx = i; end
      ack_i = (i == d);
    end
    ack_i = 1'b0;
    chk(rs != 0 ? "R8 restart count" : (d > TMO_CYC ? "R5 timeout" : "R7 ack in time"),
        hits, e != 0 ? 1 : 0);
    chk("R9 timeout position", idx, e);
  endtask

  task automatic measure_hold(output int lows, output int st_first, output int st_next);
    lows = 0;
    forever begin
      @(negedge clk);
      if (rst_drive_n) break;
      lows++;
    end
    st_first = selftest_o;
    @(negedge clk);
    st_next = selftest_o;
  endtask

  initial begin
    #(4ns * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lows, s1, s2, tmo_seen;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk("R1 reset state drive", rst_drive_n, 0);
    chk("R10 reset state tmo", tmo_ack_o, 0);
    chk("R2 reset state selftest", selftest_o, 0);
    por_n = 1'b1;
    measure_hold(lows, s1, s2);
    chk("R1 power-up hold", lows, HOLD_CYC - 1);
    chk("R2 selftest pulse", s1, 1);
    chk("R2 selftest single", s2, 0);

    run_txn(TMO_CYC - 1, 0);
    run_txn(TMO_CYC, 0);
    run_txn(TMO_CYC + 1, 0);
    run_txn(1, 0);
    run_txn(1000, 0);
    run_txn(1000, 5);
    for (int k = 0; k < 40; k++)
      run_txn($urandom_range(1, TMO_CYC + 3), 0);

    @(negedge clk); ext_n = 1'b0;
    @(negedge clk); ext_n = 1'b1;
    lows = 0;
    repeat (6) begin @(negedge clk); if (!rst_drive_n) lows++; end
    chk("R4 glitch ignored", lows, 0);

    @(negedge clk); ext_n = 1'b0;
    @(negedge clk);
    chk("R3 not yet", rst_drive_n, 1);
    @(negedge clk);
    ext_n = 1'b1;
    chk("R3 request taken", rst_drive_n, 0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lows = 2;
    tmo_seen = 0;
    forever begin
      if (tmo_ack_o) tmo_seen++;
      @(negedge clk);
      if (rst_drive_n) break;
      lows++;
    end
    s1 = selftest_o;
    chk("R3 stretched hold", lows, HOLD_CYC);
    chk("R3 selftest after request", s1, 1);
    repeat (TMO_CYC + 3) begin @(negedge clk); if (tmo_ack_o) tmo_seen++; end
    chk("R10 no timeout from reset", tmo_seen, 0);

    run_txn(1000, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule